// File: doc/BRIEF.md
# Timer Port Pin Control

This block sits between the channels of a multi-channel timer and the port pins they share. For each pin it chooses the direction and the driving source. The inputs to that choice are a global timer enable, a direction bit, a capture/compare select bit, a two-bit capture edge field, a two-bit compare action code and an override mask bit. Each channel owns one compare output latch. That latch changes on the clock edge after a compare-hit strobe, according to the channel's action code.

One channel is the override channel (index 3 by default). A compare hit there forces every masked compare channel's latch to its bit of an override data register. In the same step it copies the masked override bits into the port data register. When a compare mode drives a pin, the pin becomes an output, but the stored direction bit is left unchanged. A port data read returns the live pin level for input bits and the data register for output bits.

Each pin lane classifies itself every cycle into one of three named pin states. PM_GPIO_IN means the pin is undriven and follows the outside world. PM_GPIO_OUT means the pin is driven from the port data register. PM_CMP_DRIVE means the pin is driven from the compare latch.

Transitions between these states are combinational, and settings select them:
- Timer disabled, or the channel not in compare drive: the direction bit picks between PM_GPIO_IN and PM_GPIO_OUT.
- Timer enabled, the channel set to compare, and either a non-zero action code or a set mask bit: the lane enters PM_CMP_DRIVE.
- Clearing any of those conditions returns the lane to the direction-bit choice.

Top module: `tpc_port`

## Requirements
- R1: Reset clears every setting register, the port data register and all compare latches, so every pin_oe bit is 0 and rd_data equals pin_in.
- R2: While the enable (register 0, bit 0) is 0, pin_oe equals the direction register and pin_out equals the port data register, whatever the other settings are.
- R3: With the timer enabled and a channel's select bit 0 (capture), its pin direction follows its direction bit, its output comes from the port data register, and its mask bit has no effect.
- R4: cap_arm[i] is 1 exactly when the timer is enabled, select bit i is 0 and edge field i (bits 2i+1:2i of register 3) is non-zero. cap_src[i] is pin_out[i] when pin_oe[i] is 1 and pin_in[i] otherwise.
- R5: A compare channel (select bit 1) with action code 00 and mask bit 0 behaves as plain port I/O under its direction bit.
- R6: With the timer enabled, a compare channel with a non-zero action code or a set mask bit has pin_oe 1 and pin_out equal to its compare latch. Its stored direction bit is unchanged, which is visible through rd_data.
- R7: With the timer enabled and the select bit 1, cmp_hit[i] changes latch i at the next edge according to action code i (bits 2i+1:2i of register 4): 01 toggles it, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R8: An override hit (cmp_hit on the override channel, with the timer enabled and that channel's select bit 1) loads each compare channel's latch with bit i of the override data register (register 6) when mask bit i (register 5) is set. A channel's own non-zero action in the same cycle takes priority.
- R9: An override hit replaces the masked bits of the port data register with the override data bits. A write to the port data register (register 7) in the same cycle takes priority.
- R10: rd_data[i] is port data bit i when direction bit i is 1, and pin_in[i] when it is 0.
- R11: A write with wr_en high updates the register selected by wr_addr at the next edge. The addresses are: 0 enable, 1 direction, 2 select, 3 edge fields, 4 action codes, 5 mask, 6 override data, 7 port data.
- R12: Compare hits leave every latch unchanged while the timer is disabled, and on channels whose select bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data (narrow registers use bits 7:0) |
| cmp_hit | input | 8 | Per-channel compare-match strobes |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| rd_data | output | 8 | Port data read value |
| cap_arm | output | 8 | Capture enabled per channel |
| cap_src | output | 8 | Level presented to the capture logic |

## Verification
The hardest situation to reach is an override hit that coincides with a channel's own compare hit, a masked channel whose action code is 00, and a port-data write, all in the same cycle. Each of these needs several registers set up beforehand. Directed sequences first build those settings one register at a time, then fire the strobes together and check the pins against hand-worked values. After that, a long random phase drives writes, strobes and pin levels on every cycle, and a behavioural model compares all outputs each clock.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [1:0] {
        PM_GPIO_IN   = 2'd0,
        PM_GPIO_OUT  = 2'd1,
        PM_CMP_DRIVE = 2'd2
    } pin_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } cmp_act_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_EDGE = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd5;
    localparam logic [ADDR_W-1:0] A_OVD  = 3'd6;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd7;

endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
    import tpc_pkg::*;
#(
    parameter int NCH = 8,
    localparam int DW = 2 * NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              ovr_fire,
    output logic              en_q,
    output logic [NCH-1:0]    ddr_q,
    output logic [NCH-1:0]    sel_q,
    output logic [DW-1:0]     edge_q,
    output logic [DW-1:0]     act_q,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    ovd_q,
    output logic [NCH-1:0]    dat_q
);

    logic data_wr;
    assign data_wr = wr_en && (wr_addr == A_DATA);

    // settings registers: written only through the write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ddr_q  <= '0;
            sel_q  <= '0;
            edge_q <= '0;
            act_q  <= '0;
            mask_q <= '0;
            ovd_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  en_q   <= wr_data[0];
                A_DIR:   ddr_q  <= wr_data[NCH-1:0];
                A_SEL:   sel_q  <= wr_data[NCH-1:0];
                A_EDGE:  edge_q <= wr_data;
                A_ACT:   act_q  <= wr_data;
                A_MASK:  mask_q <= wr_data[NCH-1:0];
                A_OVD:   ovd_q  <= wr_data[NCH-1:0];
                default: ;
            endcase
        end
    end

    // port data register: a write beats the override transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else if (data_wr) begin
            dat_q <= wr_data[NCH-1:0];
        end else if (ovr_fire) begin
            dat_q <= (dat_q & ~mask_q) | (ovd_q & mask_q);
        end
    end

endmodule

// File: rtl/tpc_lane.sv
module tpc_lane
    import tpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sel,
    input  logic       ddr,
    input  logic       dat,
    input  logic       mask,
    input  logic [1:0] act,
    input  logic [1:0] edg,
    input  logic       hit,
    input  logic       ovr_fire,
    input  logic       ovr_bit,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       cap_arm,
    output logic       cap_src,
    output logic       lat_q
);

    pin_mode_e mode;
    cmp_act_e  act_e;
    logic      own_fire;

    assign act_e    = cmp_act_e'(act);
    assign own_fire = en && sel && hit && (act_e != ACT_NONE);

    // lane state selection
    always_comb begin
        if (en && sel && ((act_e != ACT_NONE) || mask)) begin
            mode = PM_CMP_DRIVE;
        end else if (ddr) begin
            mode = PM_GPIO_OUT;
        end else begin
            mode = PM_GPIO_IN;
        end
    end

    // compare latch: own action first, then override load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
        end else if (own_fire) begin
            unique case (act_e)
                ACT_TOGGLE: lat_q <= ~lat_q;
                ACT_CLEAR:  lat_q <= 1'b0;
                ACT_SET:    lat_q <= 1'b1;
                default:    lat_q <= lat_q;
            endcase
        end else if (ovr_fire && sel && mask) begin
            lat_q <= ovr_bit;
        end
    end

    // pin drive per lane state
    always_comb begin
        unique case (mode)
            PM_GPIO_IN: begin
                pin_oe  = 1'b0;
                pin_out = dat;
            end
            PM_GPIO_OUT: begin
                pin_oe  = 1'b1;
                pin_out = dat;
            end
            PM_CMP_DRIVE: begin
                pin_oe  = 1'b1;
                pin_out = lat_q;
            end
            default: begin
                pin_oe  = 1'b0;
                pin_out = dat;
            end
        endcase
    end

    assign cap_arm = en && !sel && (edg != 2'b00);
    assign cap_src = pin_oe ? pin_out : pin_in;

endmodule

// File: rtl/tpc_port.sv
module tpc_port
    import tpc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int OVR_CH = 3,
    localparam int DW    = 2 * NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH-1:0]    cmp_hit,
    input  logic [NCH-1:0]    pin_in,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_oe,
    output logic [NCH-1:0]    rd_data,
    output logic [NCH-1:0]    cap_arm,
    output logic [NCH-1:0]    cap_src
);

    logic           en_q;
    logic [NCH-1:0] ddr_q, sel_q, mask_q, ovd_q, dat_q, lat_q;
    logic [DW-1:0]  edge_q, act_q;
    logic           ovr_fire;

    assign ovr_fire = en_q && sel_q[OVR_CH] && cmp_hit[OVR_CH];

    tpc_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ovr_fire (ovr_fire),
        .en_q     (en_q),
        .ddr_q    (ddr_q),
        .sel_q    (sel_q),
        .edge_q   (edge_q),
        .act_q    (act_q),
        .mask_q   (mask_q),
        .ovd_q    (ovd_q),
        .dat_q    (dat_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        tpc_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q),
            .sel      (sel_q[i]),
            .ddr      (ddr_q[i]),
            .dat      (dat_q[i]),
            .mask     (mask_q[i]),
            .act      (act_q[2*i +: 2]),
            .edg      (edge_q[2*i +: 2]),
            .hit      (cmp_hit[i]),
            .ovr_fire (ovr_fire),
            .ovr_bit  (ovd_q[i]),
            .pin_in   (pin_in[i]),
            .pin_out  (pin_out[i]),
            .pin_oe   (pin_oe[i]),
            .cap_arm  (cap_arm[i]),
            .cap_src  (cap_src[i]),
            .lat_q    (lat_q[i])
        );
    end

    assign rd_data = (ddr_q & dat_q) | (~ddr_q & pin_in);

endmodule

// File: rtl/tpc_port_chk.sv
module tpc_port_chk
    import tpc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int OVR_CH = 3,
    localparam int DW    = 2 * NCH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NCH-1:0]    cmp_hit,
    input logic [NCH-1:0]    pin_out,
    input logic [NCH-1:0]    pin_oe,
    input logic              en_q,
    input logic [NCH-1:0]    ddr_q,
    input logic [NCH-1:0]    sel_q,
    input logic [DW-1:0]     act_q,
    input logic [NCH-1:0]    mask_q,
    input logic [NCH-1:0]    ovd_q,
    input logic [NCH-1:0]    dat_q,
    input logic [NCH-1:0]    lat_q
);

    p_reset_input_r1: assert property (@(posedge clk)
        !rst_n |-> pin_oe == '0);

    p_gpio_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (pin_oe == ddr_q) && (pin_out == dat_q));

    p_dir_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_DIR) |=> $stable(ddr_q));

    p_transfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && sel_q[OVR_CH] && cmp_hit[OVR_CH] && !(wr_en && wr_addr == A_DATA))
        |=> dat_q == (($past(dat_q) & ~$past(mask_q)) | ($past(ovd_q) & $past(mask_q))));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(lat_q));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_cmp_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q && sel_q[i] && ((act_q[2*i +: 2] != 2'b00) || mask_q[i]))
            |-> pin_oe[i] && (pin_out[i] == lat_q[i]));

        p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q && sel_q[i] && cmp_hit[i] && act_q[2*i +: 2] == 2'b11) |=> lat_q[i]);

        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q && sel_q[i] && cmp_hit[i] && act_q[2*i +: 2] == 2'b10) |=> !lat_q[i]);
    end

endmodule

bind tpc_port tpc_port_chk #(.NCH(NCH), .OVR_CH(OVR_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmp_hit (cmp_hit),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .en_q    (en_q),
    .ddr_q   (ddr_q),
    .sel_q   (sel_q),
    .act_q   (act_q),
    .mask_q  (mask_q),
    .ovd_q   (ovd_q),
    .dat_q   (dat_q),
    .lat_q   (lat_q)
);

// File: tb/tpc_port_test.sv
module tpc_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  cmp_hit = '0;
    logic [7:0]  pin_in = 8'hA5;
    logic [7:0]  pin_out, pin_oe, rd_data, cap_arm, cap_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tpc_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_hit(cmp_hit), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data),
        .cap_arm(cap_arm), .cap_src(cap_src)
    );

    // behavioural reference state
    bit         m_en;
    bit [7:0]   m_dir, m_sel, m_msk, m_ovd, m_dat, m_lat;
    bit [15:0]  m_edg, m_act;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_dir = 0; m_sel = 0; m_msk = 0; m_ovd = 0;
            m_dat = 0; m_lat = 0; m_edg = 0; m_act = 0;
        end else begin
            bit [7:0] nlat;
            bit [7:0] ndat;
            bit       ovr;
            nlat = m_lat;
            ndat = m_dat;
            ovr  = m_en && m_sel[3] && cmp_hit[3];
            for (int i = 0; i < 8; i++) begin
                int code;
                code = m_act[2*i +: 2];
                if (m_en && m_sel[i] && cmp_hit[i] && code != 0) begin
                    if (code == 1) nlat[i] = !m_lat[i];
                    else if (code == 2) nlat[i] = 0;
                    else nlat[i] = 1;
                end else if (ovr && m_sel[i] && m_msk[i]) begin
                    nlat[i] = m_ovd[i];
                end
            end
            if (ovr) ndat = (m_dat & ~m_msk) | (m_ovd & m_msk);
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_en  = wr_data[0];
                    3'd1: m_dir = wr_data[7:0];
                    3'd2: m_sel = wr_data[7:0];
                    3'd3: m_edg = wr_data;
                    3'd4: m_act = wr_data;
                    3'd5: m_msk = wr_data[7:0];
                    3'd6: m_ovd = wr_data[7:0];
                    default: ndat = wr_data[7:0];
                endcase
            end
            m_lat = nlat;
            m_dat = ndat;
        end
    end

    function automatic bit exp_drive(int i);
        return m_en && m_sel[i] && (m_act[2*i +: 2] != 0 || m_msk[i]);
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e_oe, e_out, e_rd, e_arm, e_src;
            for (int i = 0; i < 8; i++) begin
                e_oe[i]  = exp_drive(i) ? 1'b1 : m_dir[i];
                e_out[i] = exp_drive(i) ? m_lat[i] : m_dat[i];
                e_rd[i]  = m_dir[i] ? m_dat[i] : pin_in[i];
                e_arm[i] = m_en && !m_sel[i] && (m_edg[2*i +: 2] != 0);
                e_src[i] = e_oe[i] ? e_out[i] : pin_in[i];
            end
            check("R6 model pin_oe", pin_oe, e_oe);
            check("R7 model pin_out", pin_out, e_out);
            check("R10 model rd_data", rd_data, e_rd);
            check("R4 model cap_arm", cap_arm, e_arm);
            check("R4 model cap_src", cap_src, e_src);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic pulse(input logic [7:0] h);
        @(posedge clk); #1;
        cmp_hit = h;
        @(posedge clk); #1;
        cmp_hit = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        #1 rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pin_oe", pin_oe, 8'h00);
        check("R1 reset rd_data", rd_data, 8'hA5);
        #1 rst_n = 1;

        // R11 register writes, R2 timer disabled
        wr(3'd1, 16'h00F0);
        wr(3'd7, 16'h003C);
        wr(3'd2, 16'h00FF);
        wr(3'd4, 16'hFFFF);
        @(negedge clk);
        check("R2 disabled pin_oe", pin_oe, 8'hF0);
        check("R2 disabled pin_out", pin_out, 8'h3C);
        check("R10 read mix", rd_data, 8'h35);

        // R6 compare drive overrides direction
        wr(3'd0, 16'h0001);
        @(negedge clk);
        check("R6 forced output", pin_oe, 8'hFF);
        check("R6 direction kept", rd_data, 8'h35);
        pulse(8'hFF);
        @(negedge clk);
        check("R7 set action", pin_out, 8'hFF);

        // R5 / R7 toggle and clear
        wr(3'd4, 16'h0009);
        @(negedge clk);
        check("R5 action 00 follows dir", pin_oe, 8'hF3);
        pulse(8'h03);
        @(negedge clk);
        check("R7 toggle and clear", pin_out, 8'h3C);

        // R8 / R9 override
        wr(3'd5, 16'h0045);
        wr(3'd6, 16'h0055);
        @(negedge clk);
        check("R6 mask forces output", pin_oe, 8'hF7);
        pulse(8'h08);
        @(negedge clk);
        check("R8 override loads latches", pin_out, 8'h7D);
        check("R9 override transfer", rd_data, 8'h75);
        pulse(8'h09);
        @(negedge clk);
        check("R8 own action wins", pin_out, 8'h7C);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = 3'd7; wr_data = 16'h0000; cmp_hit = 8'h08;
        @(posedge clk); #1;
        wr_en = 0; cmp_hit = 0;
        @(negedge clk);
        check("R9 write beats transfer", rd_data, 8'h05);
        check("R8 override again", pin_out, 8'h45);

        // R3 / R4 capture channels
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0303);
        @(negedge clk);
        check("R3 capture ignores mask", pin_oe, 8'hF0);
        check("R4 capture armed", cap_arm, 8'h11);
        check("R4 capture source", cap_src & 8'h11, 8'h01);

        // R12 hits ignored while disabled
        wr(3'd2, 16'h00FF);
        wr(3'd4, 16'h5555);
        @(negedge clk);
        held = pin_out;
        wr(3'd0, 16'h0000);
        pulse(8'hFF);
        wr(3'd0, 16'h0001);
        @(negedge clk);
        check("R12 disabled hits ignored", pin_out, held);
        wr(3'd2, 16'h0000);
        pulse(8'hFF);
        wr(3'd2, 16'h00FF);
        @(negedge clk);
        check("R12 capture channel hits ignored", pin_out, held);

        // random phase, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_addr = 3'($urandom_range(0, 7));
            wr_data = 16'($urandom);
            cmp_hit = 8'($urandom);
            pin_in  = 8'($urandom);
            if (wr_addr == 3'd0 && wr_en) wr_data[0] = ($urandom_range(0, 3) != 0);
        end
        @(posedge clk); #1;
        wr_en = 0; cmp_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule